// File: doc/BRIEF.md
# Multi-Channel Shadowed PWM Timer

This block is a PWM timer that software drives through a small synchronous register bus. A prescale counter divides the clock. A shared timer counter advances once per prescale rollover. Seven compare values, numbered 0 to 6, are checked against that counter. Compare value 0 sets the period. Compare values 1 to 6 place the edges of six PWM outputs. Each output runs either single-edge or double-edge. Each compare value can also raise an interrupt flag, restart the counter, or freeze the counters.

In PWM mode the compare registers are double-buffered. A bus write lands in a shadow copy. It reaches the comparator only when its load-enable bit is set and a period event (a compare-0 match) follows. This way, duty changes never cut a period short. In plain timer mode, writes go straight to the comparators and the PWM outputs stay low.

Top module: `pwm_timer_top`

Register map. `bus_addr` is a word index. Reads are combinational.

| Index | Register | Fields |
|---|---|---|
| 0 | control | bit0 run, bit1 hold-in-reset, bit3 PWM mode (bit2 reads 0) |
| 1 | prescale | divider value PR |
| 2 | match actions | for compare k: bit 3k interrupt, bit 3k+1 restart counter, bit 3k+2 stop |
| 3 | output control | bits 5:0 enable outputs 1..6; bits 13:8 double-edge select for outputs 1..6 (output 1 is always single-edge) |
| 4 | load enable | bit k arms compare k for transfer |
| 5 | flags | compare 0..3 at bits 0..3, bits 4..7 always 0, compare 4..6 at bits 8..10 |
| 6 | counter | timer counter, read only |
| 8..14 | compare 0..6 | reads return the last written (shadow) value |

## Requirements
- R1: After reset, every register reads 0, all outputs are 0 and `irq` is 0.
- R2: With prescale value PR, the timer counter advances once every PR+1 clock cycles. As a result, every PWM duty count scales by PR+1.
- R3: While control bit0 (run) is 0 and bit1 is 0, the counter holds its value.
- R4: While control bit1 is 1, the counter is held at its restart value: 1 in PWM mode (control bit3 = 1), 0 in timer mode.
- R5: In single-edge mode, with period P = compare 0, output n is high for min(MRn, P) counter steps out of every P. A compare value of 0 gives a constant low, and a value of P or above gives a constant high.
- R6: In double-edge mode (output n ≥ 2, select bit 8+n-1), output n is set on compare n-1 and cleared on compare n. When 1 ≤ MR(n-1) < MRn ≤ P, it is high for MRn − MR(n-1) steps per period.
- R7: In PWM mode, a compare write changes no output until its load-enable bit is set and a period event follows. Reading the compare register back returns the new value at once.
- R8: Load-enable bits are set by writing 1. Each clears itself at the period event that transfers its value.
- R9: In timer mode, a compare write takes effect on the comparator immediately.
- R10: On a compare-k match, the match-action bits raise flag k, restart the counter, and/or clear the run bit while the counter stays at the matched value.
- R11: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high while any flag is set.
- R12: An output whose enable bit (bits 5:0 of output control) is 0 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 6 | PWM outputs 1..6 (bit n-1 is output n) |
| irq | output | 1 | OR of all flags |

## Verification
The single-edge test sweeps ten compare patterns, 0 through 9, across all six outputs with a period of 8. The sweep runs at two prescale settings. This separates the constant-low, proportional and saturated-high regions, and shows whether the duty count scales with the prescaler. A double-edge pattern with distinct start and stop values per channel tells apart the two edge sources from the single-edge rule. A pending shadow write is measured before and after its load-enable bit is armed. Timer-mode stop runs, hold-reset in both modes, and a flag sequence of write-0 and then write-1 cover the counter control and the flag behaviour.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
// Shared constants for the PWM timer: register word indices and flag layout.
// Assumes at most six outputs, so compare indices fit the 11-bit flag word.
package pwm_timer_pkg;
    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_PRESC = 4'd1;
    localparam logic [3:0] A_MACT  = 4'd2;
    localparam logic [3:0] A_OCTL  = 4'd3;
    localparam logic [3:0] A_LDEN  = 4'd4;
    localparam logic [3:0] A_FLAG  = 4'd5;
    localparam logic [3:0] A_CNT   = 4'd6;
    localparam logic [3:0] A_MR0   = 4'd8;
    localparam int         FLAG_W  = 11;

    // Flag bit that carries compare k (bits 4..7 are left free).
    function automatic int flag_pos(input int k);
        return (k < 4) ? k : k + 4;
    endfunction
endpackage

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
// Prescaler plus shared timer counter.
// Assumes reset_req/stop_req are only asserted together with tick.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             pmode,
    input  logic [CNT_W-1:0] presc,
    input  logic             reset_req,
    input  logic             stop_req,
    output logic             tick,
    output logic [CNT_W-1:0] tc
);
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] base;

    assign base = pmode ? CNT_W'(1) : '0;
    // >= so that lowering PR below the current count never stalls.
    assign tick = run && !hold && (pc_q >= presc);

    // Prescale counter: wraps after PR+1 enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pc_q <= '0;
        end else if (run) begin
            if (tick) pc_q <= '0;
            else      pc_q <= pc_q + 1'b1;
        end
    end

    // Timer counter: hold, restart, freeze on stop, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (hold) begin
            tc <= base;
        end else if (tick) begin
            if (stop_req)       tc <= tc;
            else if (reset_req) tc <= base;
            else                tc <= tc + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_match_bank.sv
`timescale 1ns/1ps
// Shadow and active compare registers with self-clearing load enables.
// Timer mode writes both copies; PWM mode writes only the shadow.
module pwm_match_bank #(
    parameter int CNT_W  = 16,
    parameter int NMATCH = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pmode,
    input  logic [NMATCH-1:0]            mr_wr,
    input  logic [CNT_W-1:0]             wdata,
    input  logic                         ld_wr,
    input  logic [NMATCH-1:0]            ld_wdata,
    input  logic                         period_evt,
    output logic [NMATCH-1:0][CNT_W-1:0] shadow,
    output logic [NMATCH-1:0][CNT_W-1:0] active,
    output logic [NMATCH-1:0][CNT_W-1:0] active_nxt,
    output logic [NMATCH-1:0]            ld_q
);
    // Next active value per compare: direct write or armed transfer.
    always_comb begin
        for (int k = 0; k < NMATCH; k++) begin
            active_nxt[k] = active[k];
            if (!pmode && mr_wr[k])           active_nxt[k] = wdata;
            else if (period_evt && ld_q[k])   active_nxt[k] = shadow[k];
        end
    end

    // Register storage for shadows, actives and load enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
            ld_q   <= '0;
        end else begin
            for (int k = 0; k < NMATCH; k++) begin
                if (mr_wr[k]) shadow[k] <= wdata;
            end
            active <= active_nxt;
            ld_q   <= (period_evt ? '0 : ld_q) | (ld_wr ? ld_wdata : '0);
        end
    end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
// One PWM output state bit. Single-edge: set at period event unless own
// compare is 0, cleared on own compare. Double-edge: set on lower
// compare, cleared on own compare (clear wins).
module pwm_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl,
    input  logic evt0,
    input  logic m_set,
    input  logic m_clr,
    input  logic own_nz,
    output logic st
);
    // Edge state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= 1'b0;
        end else if (dbl) begin
            if (m_clr)      st <= 1'b0;
            else if (m_set) st <= 1'b1;
        end else begin
            if (evt0)       st <= own_nz;
            else if (m_clr) st <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_timer_top.sv
`timescale 1ns/1ps
// Register-mapped multi-channel PWM timer with shadowed compares.
// Assumes NOUT <= 6 (register layout) and CNT_W <= 32.
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NOUT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [3:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [NOUT-1:0] pwm_out,
    output logic            irq
);
    localparam int NMATCH = NOUT + 1;
    localparam int MCW    = 3 * NMATCH;

    logic                         run_q, hold_q, pmode_q;
    logic [CNT_W-1:0]             presc_q;
    logic [MCW-1:0]               mact_q;
    logic [NOUT-1:0]              oen_q, dbl_q;
    logic [FLAG_W-1:0]            flags_q, fset;
    logic [NMATCH-1:0]            mr_wr, hit, irq_sel, rst_sel, stop_sel;
    logic [NMATCH-1:0][CNT_W-1:0] shadow_q, act_q, act_nxt;
    logic [NMATCH-1:0]            ld_q;
    logic [CNT_W-1:0]             tc_q;
    logic                         tick, period_evt, reset_req, stop_req;
    logic                         wr_ctrl, wr_ld, wr_flag;
    logic [NOUT-1:0]              st;
    logic                         unused_bits;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_ld   = bus_we && (bus_addr == A_LDEN);
    assign wr_flag = bus_we && (bus_addr == A_FLAG);
    assign unused_bits = ^{bus_wdata, dbl_q[0]};

    // Per-compare decode: write strobe, match, action selects.
    for (genvar k = 0; k < NMATCH; k++) begin : g_match
        assign mr_wr[k]    = bus_we && (bus_addr == A_MR0 + 4'(k));
        assign hit[k]      = tick && (tc_q == act_q[k]);
        assign irq_sel[k]  = mact_q[3*k];
        assign rst_sel[k]  = mact_q[3*k+1];
        assign stop_sel[k] = mact_q[3*k+2];
    end

    assign period_evt = hit[0];
    assign reset_req  = |(hit & rst_sel);
    assign stop_req   = |(hit & stop_sel);

    // Map interrupt-enabled matches onto the flag layout.
    always_comb begin
        fset = '0;
        for (int k = 0; k < NMATCH; k++) begin
            fset[flag_pos(k)] = hit[k] & irq_sel[k];
        end
    end

    // Configuration registers and run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            hold_q  <= 1'b0;
            pmode_q <= 1'b0;
            presc_q <= '0;
            mact_q  <= '0;
            oen_q   <= '0;
            dbl_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q   <= bus_wdata[0];
                hold_q  <= bus_wdata[1];
                pmode_q <= bus_wdata[3];
            end else if (stop_req) begin
                run_q   <= 1'b0;
            end
            if (bus_we && bus_addr == A_PRESC) presc_q <= bus_wdata[CNT_W-1:0];
            if (bus_we && bus_addr == A_MACT)  mact_q  <= bus_wdata[MCW-1:0];
            if (bus_we && bus_addr == A_OCTL) begin
                oen_q <= bus_wdata[NOUT-1:0];
                dbl_q <= bus_wdata[8 +: NOUT];
            end
        end
    end

    // Interrupt flags: set by matches, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(wr_flag ? bus_wdata[FLAG_W-1:0] : '0)) | fset;
    end

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_q), .hold(hold_q), .pmode(pmode_q),
        .presc(presc_q), .reset_req(reset_req), .stop_req(stop_req),
        .tick(tick), .tc(tc_q)
    );

    pwm_match_bank #(.CNT_W(CNT_W), .NMATCH(NMATCH)) u_bank (
        .clk(clk), .rst_n(rst_n), .pmode(pmode_q), .mr_wr(mr_wr),
        .wdata(bus_wdata[CNT_W-1:0]), .ld_wr(wr_ld), .ld_wdata(bus_wdata[NMATCH-1:0]),
        .period_evt(period_evt), .shadow(shadow_q), .active(act_q),
        .active_nxt(act_nxt), .ld_q(ld_q)
    );

    // One output state machine per channel; output 1 is single-edge only.
    for (genvar n = 0; n < NOUT; n++) begin : g_out
        pwm_chan u_ch (
            .clk(clk), .rst_n(rst_n),
            .dbl((n == 0) ? 1'b0 : dbl_q[n]),
            .evt0(period_evt), .m_set(hit[n]), .m_clr(hit[n+1]),
            .own_nz(|act_nxt[n+1]), .st(st[n])
        );
    end

    assign pwm_out = st & oen_q & {NOUT{pmode_q}};
    assign irq     = |flags_q;

    // Combinational register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = {28'd0, pmode_q, 1'b0, hold_q, run_q};
            A_PRESC: bus_rdata = 32'(presc_q);
            A_MACT:  bus_rdata = 32'(mact_q);
            A_OCTL:  bus_rdata = 32'({dbl_q, 2'b00, oen_q});
            A_LDEN:  bus_rdata = 32'(ld_q);
            A_FLAG:  bus_rdata = 32'(flags_q);
            A_CNT:   bus_rdata = 32'(tc_q);
            default: begin
                for (int k = 0; k < NMATCH; k++) begin
                    if (bus_addr == A_MR0 + 4'(k)) bus_rdata = 32'(shadow_q[k]);
                end
            end
        endcase
    end
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
// Property checker for pwm_timer_top, attached by bind below.
module pwm_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int NMATCH = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    hold,
    input logic                    pmode,
    input logic [CNT_W-1:0]        tc,
    input logic                    tick,
    input logic                    period_evt,
    input logic                    ld_wr,
    input logic [NMATCH-1:0]       ld,
    input logic [NMATCH*CNT_W-1:0] act,
    input logic                    irq
);
    a_r4_hold_pwm_base: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && pmode) |=> (tc == CNT_W'(1)));
    a_r4_hold_timer_base: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pmode) |=> (tc == '0));
    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> $stable(tc));
    a_r8_load_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (period_evt && !ld_wr) |=> (ld == '0));
    a_r7_active_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode && !period_evt) |=> $stable(act));
    a_r10_irq_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W), .NMATCH(NOUT + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .hold(hold_q), .pmode(pmode_q),
    .tc(tc_q), .tick(tick), .period_evt(period_evt), .ld_wr(wr_ld),
    .ld(ld_q), .act(act_q), .irq(irq)
);

// File: tb/sim_pwm_timer_top.sv
`timescale 1ns/1ps
// Self-checking bench: duty sweeps measured at the outputs, register checks.
module sim_pwm_timer_top;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cnt [6];
    logic [31:0] rv;

    always #5 clk = ~clk;

    pwm_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int win);
        for (int c = 0; c < 6; c++) cnt[c] = 0;
        repeat (win) begin
            @(negedge clk);
            for (int c = 0; c < 6; c++) if (pwm_out[c]) cnt[c]++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 15; a++) begin
            if (a != 7) begin rd(4'(a), rv); chk("R1 reg", rv, 0); end
        end
        chk("R1 pwm_out", 32'(pwm_out), 0);
        chk("R1 irq", 32'(irq), 0);

        // R9/R10: timer mode, compare 1 = 5 with stop action, written directly
        wr(4'd9, 5);
        wr(4'd2, 32'h20);
        wr(4'd0, 32'h1);
        repeat (20) @(negedge clk);
        rd(4'd6, rv); chk("R9 R10 stopped at compare", rv, 5);
        rd(4'd0, rv); chk("R10 run cleared by stop", rv, 0);
        repeat (10) @(negedge clk);
        rd(4'd6, rv); chk("R3 counter held while not running", rv, 5);
        rd(4'd5, rv); chk("R11 no flag without irq action", rv, 0);

        // R4: hold-in-reset in both modes
        wr(4'd0, 32'h2);
        repeat (2) @(negedge clk);
        rd(4'd6, rv); chk("R4 timer-mode restart value", rv, 0);
        wr(4'd0, 32'hA);
        repeat (2) @(negedge clk);
        rd(4'd6, rv); chk("R4 pwm-mode restart value", rv, 1);

        // Set period in timer mode, then start PWM
        wr(4'd0, 32'h0);
        wr(4'd8, P);
        wr(4'd2, 32'h1003);   // irq+restart on compare 0, irq on compare 4
        wr(4'd3, 32'h3F);
        wr(4'd0, 32'h9);

        // R5/R2: single-edge sweep at two prescale settings
        for (int pr = 0; pr <= 2; pr += 2) begin
            wr(4'd1, 32'(pr));
            for (int v = 0; v < 10; v++) begin
                for (int n = 1; n <= 6; n++) wr(4'(8 + n), 32'((v + 2 * (n - 1)) % 10));
                wr(4'd4, 32'h7E);
                repeat (4 * P * (pr + 1) + 4) @(negedge clk);
                measure(P * (pr + 1));
                for (int n = 1; n <= 6; n++) begin
                    int mv;
                    mv = (v + 2 * (n - 1)) % 10;
                    chk(pr == 0 ? "R5 single-edge duty" : "R2 prescaled duty",
                        32'(cnt[n-1]), 32'(((mv < P) ? mv : P) * (pr + 1)));
                end
            end
        end
        rd(4'd5, rv); chk("R11 flags after run", rv & 32'h101, 32'h101);
        chk("R11 irq high", 32'(irq), 1);

        // R6: double-edge on outputs 2, 4, 6
        wr(4'd1, 0);
        wr(4'd3, 32'h2A3F);
        wr(4'd9, 1);  wr(4'd10, 5);
        wr(4'd11, 2); wr(4'd12, 7);
        wr(4'd13, 3); wr(4'd14, 4);
        wr(4'd4, 32'h7E);
        repeat (4 * P + 4) @(negedge clk);
        measure(P);
        chk("R6 out1 single", 32'(cnt[0]), 1);
        chk("R6 out2 double", 32'(cnt[1]), 4);
        chk("R6 out3 single", 32'(cnt[2]), 2);
        chk("R6 out4 double", 32'(cnt[3]), 5);
        chk("R6 out5 single", 32'(cnt[4]), 3);
        chk("R6 out6 double", 32'(cnt[5]), 1);

        // R7/R8: pending shadow write
        wr(4'd3, 32'h3F);
        wr(4'd9, 3);
        wr(4'd4, 32'h2);
        repeat (4 * P) @(negedge clk);
        rd(4'd4, rv); chk("R8 load enable cleared", rv, 0);
        wr(4'd9, 6);
        rd(4'd9, rv); chk("R7 shadow readback", rv, 6);
        repeat (4 * P) @(negedge clk);
        measure(P);
        chk("R7 old value still active", 32'(cnt[0]), 3);
        wr(4'd4, 32'h2);
        rd(4'd4, rv); chk("R8 load enable set", rv, 2);
        repeat (4 * P) @(negedge clk);
        measure(P);
        chk("R7 new value after period", 32'(cnt[0]), 6);

        // R12: only output 1 enabled
        for (int n = 1; n <= 6; n++) wr(4'(8 + n), 4);
        wr(4'd4, 32'h7E);
        wr(4'd3, 32'h01);
        repeat (4 * P) @(negedge clk);
        measure(P);
        chk("R12 enabled output", 32'(cnt[0]), 4);
        for (int c = 1; c < 6; c++) chk("R12 disabled output low", 32'(cnt[c]), 0);

        // R11: flag clear semantics with the counter stopped
        wr(4'd0, 32'h8);
        repeat (4) @(negedge clk);
        wr(4'd5, 32'h0);
        rd(4'd5, rv); chk("R11 write 0 keeps flags", rv, 32'h101);
        wr(4'd5, 32'h1);
        rd(4'd5, rv); chk("R11 write 1 clears bit0", rv, 32'h100);
        chk("R11 irq still high", 32'(irq), 1);
        wr(4'd5, 32'h100);
        rd(4'd5, rv); chk("R11 all cleared", rv, 0);
        chk("R11 irq low", 32'(irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule